// File: doc/BRIEF.md
# Idle-Qualified Asynchronous Serial Frame Decoder

This block watches one sampled serial line and turns start/stop framed characters into decoded words, much as a protocol decoder in a logic analyzer does. The number of clock cycles in one bit period is set at run time. The data width, the parity check, the stop length and the line polarity are also set at run time. For every frame the block reports the data word, a parity error flag and a framing error flag. It also reports two cycle-count timestamps that mark where the frame begins and where it ends.

The decoder does not lock on the first low level it sees. After reset, and after any frame whose stop bit reads low, it first waits for the line to stay idle for a set number of bit periods. Only then does it accept a falling edge as a start bit. This keeps it from locking onto a data bit when a capture joins a stream partway through. Each bit is decided by a two-of-three vote over the clock samples at the bit centre and on either side of it. The include_framing input chooses how wide the timestamps are. When it is 1 they cover the start and stop bits. When it is 0 they cover only the data and parity bits.

Top module: `serial_frame_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it is released, frame_valid, frame_data, parity_err, framing_err, t_start and t_end are all zero.
- R2: After reset, and after a frame reported with framing_err, a falling edge is accepted as a start bit only once the line has read 1 for idle_bits × clks_per_bit consecutive cycles. An earlier frame produces no output.
- R3: data_bits selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. The bits are received least-significant first. The word is right-aligned in frame_data and the unused upper bits are 0.
- R4: Let a bit period start at cycle B, and let D = clks_per_bit, with D ≥ 4. The bit value is the majority of the line samples at cycles B + ⌊D/2⌋ − 1, B + ⌊D/2⌋ and B + ⌊D/2⌋ + 1. A one-cycle pulse of the wrong level inside that window does not change the result.
- R5: If the start bit votes 1, the event is dropped with no output. The decoder goes straight back to waiting for a start edge, without a new idle wait.
- R6: parity_mode 0 or 3 means there is no parity bit, 1 means even parity and 2 means odd parity. parity_err is 1 when the received parity bit does not match the data. It is always 0 when there is no parity bit.
- R7: If the first stop bit votes 0, the frame is still reported, with framing_err = 1.
- R8: stop_mode 0 gives 1 stop bit period, 1 gives 1.5 periods, and 2 or 3 give 2 periods. A start edge that comes directly after the stop period ends is accepted, so frames sent back to back are all decoded.
- R9: frame_valid is high for exactly one cycle, ⌊D/2⌋ + 2 cycles after the first stop bit begins. frame_data and both error flags are valid on that cycle.
- R10: The timestamps count clock cycles from 0 at reset. The start cycle E is the count when the first 0 of a frame is sampled. With include_framing = 1, t_start = E and t_end is the last cycle of the stop period. With include_framing = 0, t_start = E + D and t_end is the last cycle of the parity bit, or of the last data bit when there is no parity bit.
- R11: When invert is 1, the line is inverted before decoding. Idle is then the low level and every bit is read inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Sampled serial line |
| invert | input | 1 | Invert the line before decoding |
| clks_per_bit | input | DIV_W | Clock cycles per bit period, 4 or more |
| data_bits | input | 4 | Number of data bits, 5 to 9 |
| parity_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| stop_mode | input | 2 | 0: 1 bit, 1: 1.5 bits, 2 or 3: 2 bits |
| idle_bits | input | IDLE_W | Idle bit periods needed before a start edge is accepted |
| include_framing | input | 1 | Timestamps include the start and stop bits |
| frame_valid | output | 1 | One-cycle pulse for each decoded frame |
| frame_data | output | 9 | Received word, right-aligned |
| parity_err | output | 1 | Parity mismatch in this frame |
| framing_err | output | 1 | Stop bit read as 0 |
| t_start | output | TS_W | Cycle at which the frame begins |
| t_end | output | TS_W | Cycle at which the frame ends |

## Verification
The hardest state to reach is the one where the decoder is not yet idle-qualified while a complete, well-formed frame arrives. That frame must leave no trace: no output, and no false lock on one of its data bits later. The stimulus reaches this state twice. Once it starts an all-zero frame a few cycles after reset. Once it sends an all-zero frame directly behind a frame whose stop bit is low. In both cases a frame sent after a long enough idle gap must then decode exactly. The same per-cycle model also covers two other cases. One is a start pulse too short to survive the vote, followed at once by a real frame. The other is a one-cycle glitch placed right on a data-bit or stop-bit centre.

// File: rtl/serial_frame_decoder.sv
`timescale 1ns/1ps
module serial_frame_decoder #(
  parameter int DIV_W  = 16,
  parameter int TS_W   = 32,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              invert,
  input  logic [DIV_W-1:0]  clks_per_bit,
  input  logic [3:0]        data_bits,
  input  logic [1:0]        parity_mode,
  input  logic [1:0]        stop_mode,
  input  logic [IDLE_W-1:0] idle_bits,
  input  logic              include_framing,
  output logic              frame_valid,
  output logic [8:0]        frame_data,
  output logic              parity_err,
  output logic              framing_err,
  output logic [TS_W-1:0]   t_start,
  output logic [TS_W-1:0]   t_end
);

  typedef enum logic [1:0] {QUAL, HUNT, BITS, TAIL} st_t;
  st_t st;

  logic [TS_W-1:0]   now, edge_ts, bit_ts;
  logic [DIV_W-1:0]  ph, idle_cnt;
  logic [IDLE_W-1:0] idle_run;
  logic [DIV_W:0]    rem;
  logic [3:0]        bidx;
  logic [8:0]        sh;
  logic              s0, s1, perr_q;

  wire             s        = line_in ^ invert;
  wire [DIV_W-1:0] half     = clks_per_bit >> 1;
  wire [DIV_W-1:0] last_ph  = clks_per_bit - 1'b1;
  wire [3:0]       nb       = (data_bits < 4'd5) ? 4'd5 : (data_bits > 4'd9) ? 4'd9 : data_bits;
  wire             pen      = (parity_mode == 2'd1) || (parity_mode == 2'd2);
  wire [3:0]       par_idx  = nb + 4'd1;
  wire             v        = (s0 & s1) | (s0 & s) | (s1 & s);
  wire [8:0]       dw       = sh >> (4'd9 - nb);
  wire [TS_W-1:0]  d_ts     = TS_W'(clks_per_bit);
  wire [TS_W-1:0]  stop_len = (stop_mode == 2'd0) ? d_ts :
                              (stop_mode == 2'd1) ? d_ts + TS_W'(half) : d_ts << 1;
  wire [DIV_W:0]   dx       = {1'b0, clks_per_bit};
  wire [DIV_W:0]   tail_wait = (stop_mode == 2'd1) ? dx - (DIV_W+1)'(3)
                                                   : (dx << 1) - {1'b0, half} - (DIV_W+1)'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= QUAL; now <= '0; edge_ts <= '0; bit_ts <= '0;
      ph <= '0; idle_cnt <= '0; idle_run <= '0; rem <= '0; bidx <= '0;
      sh <= '0; s0 <= 1'b1; s1 <= 1'b1; perr_q <= 1'b0;
      frame_valid <= 1'b0; frame_data <= '0; parity_err <= 1'b0;
      framing_err <= 1'b0; t_start <= '0; t_end <= '0;
    end else begin
      now <= now + 1'b1;
      frame_valid <= 1'b0;
      case (st)
        QUAL: begin
          if (idle_run == idle_bits) st <= HUNT;
          else if (!s) begin
            idle_cnt <= '0; idle_run <= '0;
          end else if (idle_cnt == last_ph) begin
            idle_cnt <= '0; idle_run <= idle_run + 1'b1;
          end else idle_cnt <= idle_cnt + 1'b1;
        end
        HUNT: if (!s) begin
          st <= BITS; ph <= DIV_W'(1); bidx <= '0;
          edge_ts <= now; bit_ts <= now; perr_q <= 1'b0;
        end
        BITS: begin
          if (ph == last_ph) begin
            ph <= '0; bidx <= bidx + 1'b1; bit_ts <= bit_ts + d_ts;
          end else ph <= ph + 1'b1;
          if (ph == half - 1'b1) s0 <= s;
          if (ph == half) s1 <= s;
          if (ph == half + 1'b1) begin
            if (bidx == 4'd0) begin
              if (v) st <= HUNT;
            end else if (bidx <= nb) begin
              sh <= {v, sh[8:1]};
            end else if (pen && bidx == par_idx) begin
              perr_q <= (^dw) ^ v ^ (parity_mode == 2'd2);
            end else begin
              frame_valid <= 1'b1;
              frame_data  <= dw;
              parity_err  <= perr_q;
              framing_err <= !v;
              t_start     <= include_framing ? edge_ts : edge_ts + d_ts;
              t_end       <= include_framing ? bit_ts + stop_len - 1'b1 : bit_ts - 1'b1;
              if (!v) begin
                st <= QUAL; idle_cnt <= '0; idle_run <= '0;
              end else if (stop_mode == 2'd0) st <= HUNT;
              else begin
                st <= TAIL; rem <= tail_wait;
              end
            end
          end
        end
        TAIL: if (rem == '0) st <= HUNT; else rem <= rem - 1'b1;
        default: st <= QUAL;
      endcase
    end
  end

endmodule

// File: rtl/serial_frame_decoder_chk.sv
`timescale 1ns/1ps
module serial_frame_decoder_chk #(
  parameter int DIV_W = 16,
  parameter int TS_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic             include_framing,
  input logic [8:0]       frame_data,
  input logic [3:0]       data_bits,
  input logic [1:0]       parity_mode,
  input logic [1:0]       stop_mode,
  input logic [DIV_W-1:0] clks_per_bit,
  input logic [TS_W-1:0]  t_start,
  input logic [TS_W-1:0]  t_end,
  input logic [TS_W-1:0]  now
);

  logic [3:0] nbc;
  assign nbc = (data_bits < 4'd5) ? 4'd5 : (data_bits > 4'd9) ? 4'd9 : data_bits;
  wire [TS_W-1:0] dts  = TS_W'(clks_per_bit);
  wire [TS_W-1:0] npar = TS_W'(nbc) + TS_W'((parity_mode == 2'd1) || (parity_mode == 2'd2));
  wire [TS_W-1:0] slen = (stop_mode == 2'd0) ? dts :
                         (stop_mode == 2'd1) ? dts + (dts >> 1) : dts << 1;
  wire [TS_W-1:0] span = t_end - t_start + TS_W'(1);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_data >> nbc) == 9'd0);

  a_r10_data_span: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !include_framing) |-> span == npar * dts);

  a_r8_full_span: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && include_framing) |-> span == (npar + TS_W'(1)) * dts + slen);

  a_r10_start_past: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> t_start < now);

endmodule

bind serial_frame_decoder serial_frame_decoder_chk #(.DIV_W(DIV_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .include_framing(include_framing),
  .frame_data(frame_data), .data_bits(data_bits), .parity_mode(parity_mode),
  .stop_mode(stop_mode), .clks_per_bit(clks_per_bit), .t_start(t_start), .t_end(t_end),
  .now(now)
);

// File: tb/sim_serial_frame_decoder.sv
`timescale 1ns/1ps
module sim_serial_frame_decoder;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0, line_in = 1'b1, invert = 1'b0, include_framing = 1'b1;
  logic [15:0] clks_per_bit = 16'(D);
  logic [3:0]  data_bits = 4'd8;
  logic [1:0]  parity_mode = 2'd0, stop_mode = 2'd0;
  logic [7:0]  idle_bits = 8'd3;
  logic        frame_valid, parity_err, framing_err;
  logic [8:0]  frame_data;
  logic [31:0] t_start, t_end;

  serial_frame_decoder u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .invert(invert),
    .clks_per_bit(clks_per_bit), .data_bits(data_bits), .parity_mode(parity_mode),
    .stop_mode(stop_mode), .idle_bits(idle_bits), .include_framing(include_framing),
    .frame_valid(frame_valid), .frame_data(frame_data), .parity_err(parity_err),
    .framing_err(framing_err), .t_start(t_start), .t_end(t_end)
  );

  always #5 clk = ~clk;

  int unsigned bc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bc <= 0; else bc <= bc + 1;

  typedef struct packed {
    logic [31:0] at;
    logic [31:0] ts;
    logic [31:0] te;
    logic [8:0]  data;
    logic        pe;
    logic        fe;
  } exp_t;

  exp_t  q[$];
  int    vectors = 0, errors = 0;
  string cur_tag = "R1";
  bit    done = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_tag, what, act, exp, bc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && bc == q[0].at) begin
        chk("R9 frame_valid", 32'(frame_valid), 32'd1);
        chk("R3 frame_data", 32'(frame_data), 32'(q[0].data));
        chk("R6 parity_err", 32'(parity_err), 32'(q[0].pe));
        chk("R7 framing_err", 32'(framing_err), 32'(q[0].fe));
        chk("R10 t_start", t_start, q[0].ts);
        chk("R10 t_end", t_end, q[0].te);
        void'(q.pop_front());
      end else begin
        chk("R9 no frame_valid", 32'(frame_valid), 32'd0);
      end
    end
  end

  task automatic idle(input int n);
    line_in = 1'b1 ^ invert;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input bit badpar,
                      input bit stopv, input bit expect_it, input int glitch);
    int          pen = (parity_mode == 2'd1 || parity_mode == 2'd2) ? 1 : 0;
    int          ks  = 1 + nb + pen;
    int          sl  = (stop_mode == 2'd0) ? D : (stop_mode == 2'd1) ? D + D / 2 : 2 * D;
    int unsigned e0  = bc;
    logic        par = 1'b0;
    exp_t        e;
    data_bits = 4'(nb);
    for (int i = 0; i < nb; i++) par = par ^ d[i];
    if (parity_mode == 2'd2) par = ~par;
    if (badpar) par = ~par;
    if (expect_it) begin
      e.at   = 32'(e0 + ks * D + D / 2 + 2);
      e.data = d & 9'((1 << nb) - 1);
      e.pe   = badpar && (pen == 1);
      e.fe   = !stopv;
      e.ts   = include_framing ? 32'(e0) : 32'(e0 + D);
      e.te   = include_framing ? 32'(e0 + ks * D + sl - 1) : 32'(e0 + ks * D - 1);
      q.push_back(e);
    end
    for (int j = 0; j < ks * D + sl; j++) begin
      int   k = j / D;
      logic lv;
      if (k == 0) lv = 1'b0;
      else if (k <= nb) lv = d[k-1];
      else if (pen == 1 && k == nb + 1) lv = par;
      else lv = stopv;
      if (j == glitch) lv = ~lv;
      line_in = lv ^ invert;
      @(negedge clk);
    end
    line_in = 1'b1 ^ invert;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    line_in = 1'b1 ^ invert;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk("R1 valid in reset", 32'(frame_valid), 32'd0);
    chk("R1 t_end in reset", t_end, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 frame_data", 32'(frame_data), 32'd0);
    chk("R1 flags", {30'd0, parity_err, framing_err}, 32'd0);
    chk("R1 t_start", t_start, 32'd0);
    chk("R1 t_end", t_end, 32'd0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL R9 watchdog expired at cycle %0d", bc);
    finish_up();
  end

  initial begin
    do_reset();

    cur_tag = "R2";
    idle(2);
    send(9'h000, 8, 0, 1, 0, -1);
    idle(D * 4 + 8);
    send(9'h05A, 8, 0, 1, 1, -1);

    cur_tag = "R3";
    idle(D);
    send(9'h015, 5, 0, 1, 1, -1);
    idle(3);
    send(9'h04B, 7, 0, 1, 1, -1);
    send(9'h1A5, 9, 0, 1, 1, -1);
    idle(D * 2);
    send(9'h100, 9, 0, 1, 1, -1);
    send(9'h1FF, 5, 0, 1, 1, -1);

    cur_tag = "R6";
    parity_mode = 2'd1;
    send(9'h03C, 8, 0, 1, 1, -1);
    send(9'h03D, 8, 1, 1, 1, -1);
    parity_mode = 2'd2;
    send(9'h007, 7, 0, 1, 1, -1);
    send(9'h000, 6, 1, 1, 1, -1);
    parity_mode = 2'd3;
    send(9'h0C3, 8, 0, 1, 1, -1);
    parity_mode = 2'd0;

    cur_tag = "R4";
    idle(5);
    send(9'h000, 8, 0, 1, 1, 3 * D + D / 2);
    send(9'h0FF, 8, 0, 1, 1, 5 * D + D / 2 - 1);
    send(9'h055, 8, 0, 1, 1, 9 * D + D / 2 + 1);
    send(9'h0AA, 8, 0, 1, 1, D / 2);

    cur_tag = "R5";
    idle(D);
    line_in = 1'b0;
    repeat (3) @(negedge clk);
    idle(D);
    send(9'h0A5, 8, 0, 1, 1, -1);

    cur_tag = "R8";
    stop_mode = 2'd1;
    send(9'h011, 8, 0, 1, 1, -1);
    send(9'h0EE, 8, 0, 1, 1, -1);
    stop_mode = 2'd2;
    send(9'h022, 8, 0, 1, 1, -1);
    send(9'h0DD, 8, 0, 1, 1, -1);
    stop_mode = 2'd3;
    send(9'h123, 9, 0, 1, 1, -1);
    stop_mode = 2'd0;

    cur_tag = "R10";
    include_framing = 1'b0;
    idle(7);
    send(9'h069, 8, 0, 1, 1, -1);
    parity_mode = 2'd1;
    send(9'h01F, 5, 0, 1, 1, -1);
    stop_mode = 2'd2;
    send(9'h0F0, 8, 0, 1, 1, -1);
    stop_mode = 2'd0;
    parity_mode = 2'd0;
    include_framing = 1'b1;

    cur_tag = "R7";
    idle(D);
    send(9'h033, 8, 0, 0, 1, -1);
    send(9'h000, 8, 0, 1, 0, -1);
    idle(D * 4 + 8);
    send(9'h081, 8, 0, 1, 1, -1);

    cur_tag = "R11";
    invert = 1'b1;
    do_reset();
    cur_tag = "R11";
    idle(D * 4 + 8);
    send(9'h0C6, 8, 0, 1, 1, -1);
    parity_mode = 2'd2;
    send(9'h039, 8, 0, 1, 1, -1);
    parity_mode = 2'd0;

    idle(D * 3);
    cur_tag = "R9";
    chk("R9 frames still pending", 32'(q.size()), 32'd0);
    finish_up();
  end

endmodule